// File: doc/BRIEF.md
# Ant colony random bit generator

This block produces a pseudo-random bitstream from a small simulated colony. A ring of cells holds a food count in each cell, and a group of ants walks around the ring. A loaded chromosome gives every ant its own stride length. A one-dimensional rule-30 cellular automaton gives the left or right choice for each move. After it moves, an ant either picks up food or drops the food it carries, depending on how much food lies in its new cell. The output bits are the ants' food-carrying flags.

The owner loads a chromosome and a 32-bit seed, either during synchronous reset or with a one-cycle load strobe. Each pulse of the step input then runs one colony step. In a step the ants are updated one per cycle, in index order. The block then shifts out every ant's carry flag, ant 0 first, with a valid strobe. The colony size is a parameter and is meant to be 20 or 32. The ring length must be a power of two that is at least twice the colony size.

Top module: `ant_colony_rng`

## Requirements
- R1: A clock edge with rst_n low makes the same initialisation as a load. The automaton state takes seedIn. Cell c gets food {0, seedIn[(c+1) mod 32], seedIn[c mod 32]} (a value from 0 to 3). Ant i starts at cell 2*i, and no ant carries food. bitValid stays low until the first step produces output.
- R2: Ant i reads its range code from chromoIn[3i+2:3i]. A code r from 0 to 5 moves the ant r+1 cells. Codes 6 and 7 act as code 5.
- R3: Ant positions wrap modulo 64. A move below cell 0 or above cell 63 continues from the other end of the ring.
- R4: The direction for each ant update is bit 16 of a 32-bit automaton, sampled before the automaton advances; 1 moves the ant to higher cell numbers and 0 to lower. The automaton advances once per ant update and at no other time. The update is new[i] = s[i-1] XOR (s[i] OR s[i+1]), with indices taken modulo 32.
- R5: An ant that carries food and lands on a cell holding 0 or 1 food leaves the food there. The cell count rises by one and the ant's carry flag clears.
- R6: An ant that carries nothing and lands on a cell holding any food picks one unit up. The cell count falls by one and the ant's carry flag sets.
- R7: Within a step the ants are updated one per cycle, from ant 0 to ant N-1. A later ant sees the cell contents that earlier ants left behind.
- R8: Take the edge that samples stepEn high while idle as edge 0. The first output bit is on bitOut N+1 cycles after that edge. bitValid then stays high for exactly N consecutive cycles, carrying ant 0's carry flag first and ant N-1's last. bitOut is 0 whenever bitValid is low.
- R9: stepEn is ignored while the ants are being updated and while bits are being shifted out. Holding it high through a step produces exactly one step.
- R10: A loadEn pulse reinitialises the block as in R1 at any time, including in the middle of a shift. bitValid is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads chromoIn and seedIn |
| loadEn | input | 1 | Load strobe for chromosome and seed |
| chromoIn | input | NUM_ANTS*3 | Range codes, 3 bits per ant, ant 0 in the low bits |
| seedIn | input | 32 | Automaton state and initial food pattern |
| stepEn | input | 1 | Starts one colony step when idle |
| bitOut | output | 1 | Serial carry flag of the polled ant |
| bitValid | output | 1 | High while bitOut carries a colony bit |

## Verification
A bad position, a bad automaton bit or a bad food count is hidden until an ant's carry decision depends on it. Most such errors change at least one carry flag within the same step, and that flag shows up in the serial burst between N+1 and 2N cycles after stepEn. Some errors affect only cells that no ant has visited yet. These appear only after several steps, so the bench runs several steps after each load and compares every bit against a reference model of the colony.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  localparam int CA_WIDTH  = 32;
  localparam int CA_CENTER = 16;
  localparam int CODE_W    = 3;
  localparam int MAX_CODE  = 5;

  typedef struct packed {
    logic load;   // initialise colony from chromosome and seed
    logic move;   // update the selected ant this cycle
    logic shift;  // present the selected ant's flag on the output
  } acg_strobe_t;
endpackage

// File: rtl/acg_ca.sv
`timescale 1ns/1ps
module acg_ca #(
  parameter int WIDTH  = 32,
  parameter int CENTER = 16
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             advance,
  output logic             dirBit
);
  logic [WIDTH-1:0] caState;
  logic [WIDTH-1:0] caNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rule
    assign caNext[i] = caState[(i + WIDTH - 1) % WIDTH] ^
                       (caState[i] | caState[(i + 1) % WIDTH]);
  end

  always_ff @(posedge clk) begin
    if (load)         caState <= seed;
    else if (advance) caState <= caNext;
  end

  assign dirBit = caState[CENTER];
endmodule

// File: rtl/acg_ctrl.sv
`timescale 1ns/1ps
module acg_ctrl
  import acg_pkg::*;
#(
  parameter int NUM_ANTS = 20,
  localparam int AW = $clog2(NUM_ANTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loadEn,
  input  logic          stepEn,
  output acg_strobe_t   strobe,
  output logic [AW-1:0] antSel,
  output logic          bitValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_SHIFT} ctrl_state_t;

  localparam logic [AW-1:0] LAST = AW'(NUM_ANTS - 1);

  ctrl_state_t state;
  logic        loadNow;

  assign loadNow = !rst_n || loadEn;

  always_ff @(posedge clk) begin
    if (loadNow) begin
      state  <= ST_IDLE;
      antSel <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (stepEn) begin
          state  <= ST_MOVE;
          antSel <= '0;
        end
        ST_MOVE: begin
          if (antSel == LAST) begin
            state  <= ST_SHIFT;
            antSel <= '0;
          end else begin
            antSel <= antSel + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (antSel == LAST) begin
            state  <= ST_IDLE;
            antSel <= '0;
          end else begin
            antSel <= antSel + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = loadNow;
    strobe.move  = (state == ST_MOVE) && !loadNow;
    strobe.shift = (state == ST_SHIFT) && !loadNow;
  end

  assign bitValid = (state == ST_SHIFT);

  // R8: the burst ends after the last ant's bit
  a_r8_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid && antSel == LAST && !loadEn |=> !bitValid);

  // R9: an active shift runs on regardless of stepEn
  a_r9_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SHIFT && antSel != LAST && !loadEn |=> state == ST_SHIFT);

  // R10: a load ends any burst and returns to idle
  a_r10_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |=> !bitValid && state == ST_IDLE);
endmodule

// File: rtl/acg_datapath.sv
`timescale 1ns/1ps
module acg_datapath
  import acg_pkg::*;
#(
  parameter int NUM_ANTS  = 20,
  parameter int NUM_CELLS = 64,
  parameter int FOOD_W    = 3,
  localparam int AW = $clog2(NUM_ANTS),
  localparam int PW = $clog2(NUM_CELLS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  acg_strobe_t                strobe,
  input  logic [AW-1:0]              antSel,
  input  logic [NUM_ANTS*CODE_W-1:0] chromo,
  input  logic [CA_WIDTH-1:0]        seed,
  output logic                       bitOut
);
  logic [FOOD_W-1:0] food [NUM_CELLS];
  logic [PW-1:0]     pos [NUM_ANTS];
  logic [CODE_W-1:0] rangeCode [NUM_ANTS];
  logic [NUM_ANTS-1:0] carry;

  logic              dirBit;
  logic [PW-1:0]     curPos, newPos, stepLen;
  logic [CODE_W-1:0] curCode;
  logic [FOOD_W-1:0] cellFood, foodInc, foodDec;
  logic              doDrop, doPick, carrying;

  acg_ca #(.WIDTH(CA_WIDTH), .CENTER(CA_CENTER)) u_ca (
    .clk    (clk),
    .load   (strobe.load),
    .seed   (seed),
    .advance(strobe.move),
    .dirBit (dirBit)
  );

  always_comb begin
    curPos   = pos[antSel];
    curCode  = rangeCode[antSel];
    stepLen  = (curCode > CODE_W'(MAX_CODE)) ? PW'(MAX_CODE + 1)
                                             : PW'(curCode) + PW'(1);
    newPos   = dirBit ? curPos + stepLen : curPos - stepLen;
    cellFood = food[newPos];
    carrying = carry[antSel];
    foodInc  = (cellFood == '1) ? cellFood : cellFood + FOOD_W'(1);
    foodDec  = cellFood - FOOD_W'(1);
    doDrop   = carrying && (cellFood <= FOOD_W'(1));
    doPick   = !carrying && (cellFood != '0);
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int c = 0; c < NUM_CELLS; c++) begin
        food[c] <= {{(FOOD_W-2){1'b0}}, seed[(c + 1) % CA_WIDTH], seed[c % CA_WIDTH]};
      end
      for (int i = 0; i < NUM_ANTS; i++) begin
        pos[i]       <= PW'(2 * i);
        rangeCode[i] <= chromo[CODE_W*i +: CODE_W];
      end
      carry <= '0;
    end else if (strobe.move) begin
      pos[antSel] <= newPos;
      if (doDrop) begin
        food[newPos]  <= foodInc;
        carry[antSel] <= 1'b0;
      end else if (doPick) begin
        food[newPos]  <= foodDec;
        carry[antSel] <= 1'b1;
      end
    end
  end

  assign bitOut = strobe.shift && carry[antSel];

  // R2 R3: a moved ant lands exactly one stride away, modulo the ring
  a_r2_stride: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.move |=> (pos[$past(antSel)] == $past(curPos) + $past(stepLen)) ||
                    (pos[$past(antSel)] == $past(curPos) - $past(stepLen)));

  // R5: carrying ant on a sparse cell ends up empty-handed
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.move && carrying && cellFood <= FOOD_W'(1) |=> !carry[$past(antSel)]);

  // R6: empty-handed ant on a food cell ends up carrying
  a_r6_pickup: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.move && !carrying && cellFood != '0 |=> carry[$past(antSel)]);

  // R8: no bit leaves outside a shift
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.shift |-> !bitOut);
endmodule

// File: rtl/ant_colony_rng.sv
`timescale 1ns/1ps
module ant_colony_rng
  import acg_pkg::*;
#(
  parameter int NUM_ANTS  = 20,
  parameter int NUM_CELLS = 64,
  parameter int FOOD_W    = 3,
  localparam int AW = $clog2(NUM_ANTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loadEn,
  input  logic [NUM_ANTS*3-1:0]   chromoIn,
  input  logic [31:0]             seedIn,
  input  logic                    stepEn,
  output logic                    bitOut,
  output logic                    bitValid
);
  acg_strobe_t   strobe;
  logic [AW-1:0] antSel;

  acg_ctrl #(.NUM_ANTS(NUM_ANTS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .loadEn  (loadEn),
    .stepEn  (stepEn),
    .strobe  (strobe),
    .antSel  (antSel),
    .bitValid(bitValid)
  );

  acg_datapath #(
    .NUM_ANTS (NUM_ANTS),
    .NUM_CELLS(NUM_CELLS),
    .FOOD_W   (FOOD_W)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .antSel(antSel),
    .chromo(chromoIn),
    .seed  (seedIn),
    .bitOut(bitOut)
  );
endmodule

// File: tb/ant_colony_rng_bench.sv
`timescale 1ns/1ps
module ant_colony_rng_bench;
  localparam int N     = 20;
  localparam int CELLS = 64;

  logic clk = 1'b0;
  logic rst_n, loadEn, stepEn;
  logic [N*3-1:0] chromoIn;
  logic [31:0]    seedIn;
  logic bitOut, bitValid;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  ant_colony_rng #(.NUM_ANTS(N), .NUM_CELLS(CELLS)) u_ant_colony_rng (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .chromoIn(chromoIn),
    .seedIn(seedIn), .stepEn(stepEn), .bitOut(bitOut), .bitValid(bitValid)
  );

  // reference colony
  int          mPos [N];
  int          mCode [N];
  bit          mCarry [N];
  int          mFood [CELLS];
  logic [31:0] mCa;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] caNext(input logic [31:0] s);
    logic [31:0] n;
    for (int i = 0; i < 32; i++)
      n[i] = s[(i + 31) % 32] ^ (s[i] | s[(i + 1) % 32]);
    return n;
  endfunction

  task automatic modelInit(input logic [N*3-1:0] c, input logic [31:0] s);
    mCa = s;
    for (int k = 0; k < CELLS; k++)
      mFood[k] = 2 * int'(s[(k + 1) % 32]) + int'(s[k % 32]);
    for (int i = 0; i < N; i++) begin
      mPos[i]   = 2 * i;
      mCode[i]  = int'(c[3*i +: 3]);
      mCarry[i] = 1'b0;
    end
  endtask

  task automatic modelStep();
    for (int i = 0; i < N; i++) begin
      int len;
      bit dir;
      dir = mCa[16];
      mCa = caNext(mCa);
      len = ((mCode[i] > 5) ? 5 : mCode[i]) + 1;
      mPos[i] = dir ? (mPos[i] + len) % CELLS : (mPos[i] - len + CELLS) % CELLS;
      if (mCarry[i] && mFood[mPos[i]] <= 1) begin
        mFood[mPos[i]] = mFood[mPos[i]] + 1;
        mCarry[i] = 1'b0;
      end else if (!mCarry[i] && mFood[mPos[i]] != 0) begin
        mFood[mPos[i]] = mFood[mPos[i]] - 1;
        mCarry[i] = 1'b1;
      end
    end
  endtask

  // starts and ends at a negedge
  task automatic doLoad(input logic [N*3-1:0] c, input logic [31:0] s);
    chromoIn = c;
    seedIn   = s;
    loadEn   = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    modelInit(c, s);
    check(!bitValid, "R10 valid low after load", int'(bitValid), 0);
  endtask

  task automatic doStep(input bit hold, input string tag);
    int cnt;
    modelStep();
    stepEn = 1'b1;
    @(negedge clk);
    if (!hold) stepEn = 1'b0;
    cnt = 1;
    while (!bitValid && cnt < 3 * N) begin
      check(bitOut == 1'b0, "R8 bitOut zero while invalid", int'(bitOut), 0);
      @(negedge clk);
      cnt++;
    end
    check(cnt == N + 1, "R8 latency to first bit", cnt, N + 1);
    for (int k = 0; k < N; k++) begin
      check(bitValid, "R8 valid run length", int'(bitValid), 1);
      check(bitOut == mCarry[k], {tag, " R5 R6 R7 ant flag"}, int'(bitOut), int'(mCarry[k]));
      if (k == N - 1) stepEn = 1'b0;
      @(negedge clk);
    end
    check(!bitValid, "R9 single step per request", int'(bitValid), 0);
    @(negedge clk);
    check(!bitValid, "R9 no second burst", int'(bitValid), 0);
  endtask

  function automatic logic [N*3-1:0] randChromo();
    logic [N*3-1:0] c;
    for (int i = 0; i < N; i++) c[3*i +: 3] = 3'($urandom_range(0, 7));
    return c;
  endfunction

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; loadEn = 1'b0; stepEn = 1'b0;
    chromoIn = '0;
    seedIn   = 32'h0001_0000;
    repeat (3) @(negedge clk);
    check(!bitValid, "R1 valid low in reset", int'(bitValid), 0);
    check(!bitOut, "R1 bitOut low in reset", int'(bitOut), 0);
    modelInit(chromoIn, seedIn);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(!bitValid, "R1 valid low before first step", int'(bitValid), 0);
    end

    // stride 1, single-centre seed, ant 0 wraps below cell 0
    for (int s = 0; s < 3; s++) doStep(1'b0, "R1 R3 R4");

    // all codes 7: clamp to stride 6
    doLoad({N{3'd7}}, 32'hA5C3_0F96);
    for (int s = 0; s < 3; s++) doStep(1'b0, "R2");

    // codes 5 and 6 mixed
    begin
      logic [N*3-1:0] c;
      for (int i = 0; i < N; i++) c[3*i +: 3] = (i % 2 == 0) ? 3'd5 : 3'd6;
      doLoad(c, 32'hFFFF_FFFF);
      doStep(1'b0, "R2 R5");
      doStep(1'b0, "R2 R5");
    end

    // stepEn held high through whole step
    doLoad(randChromo(), $urandom());
    doStep(1'b1, "R9");
    doStep(1'b1, "R9");

    // load in the middle of a burst
    doLoad(randChromo(), $urandom());
    stepEn = 1'b1;
    @(negedge clk);
    stepEn = 1'b0;
    while (!bitValid) @(negedge clk);
    repeat (3) @(negedge clk);
    doLoad(randChromo(), $urandom());
    @(negedge clk);
    check(!bitValid, "R10 burst stays ended", int'(bitValid), 0);
    doStep(1'b0, "R10");
    doStep(1'b0, "R10");

    // random chromosomes and seeds
    for (int r = 0; r < 8; r++) begin
      doLoad(randChromo(), $urandom());
      for (int s = 0; s < 4; s++) doStep(1'b0, "R6 R4");
    end

    // reset also reloads
    rst_n = 1'b0;
    chromoIn = randChromo();
    seedIn = $urandom();
    @(negedge clk);
    rst_n = 1'b1;
    modelInit(chromoIn, seedIn);
    check(!bitValid, "R1 valid low after reset", int'(bitValid), 0);
    doStep(1'b0, "R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule